// File: doc/BRIEF.md
# Editable Time-of-Day Clock Controller

This block keeps a 24-hour time of day as binary hours, minutes and seconds. A prescaler counts millisecond ticks and produces a one-second strobe. While no edit switch is on, each strobe advances the seconds, and carries ripple through minutes and hours. At midnight the time wraps to zero.

Three field-select switches place the block in an edit mode for hours, minutes or seconds. In an edit mode the normal count stops. The up or down switch then moves only the chosen field by one on each strobe, wrapping within that field's own range.

The current mode is an output, so a display driver can flash the field being edited. Switch debouncing and display driving belong to other blocks.

Top module: `clock_edit_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset the outputs show 19:55:50, mode reads 0 (running), and the tick prescaler is cleared.
- R2: The one-second strobe fires on the TICKS_PER_SEC-th millisecond tick after reset or after the previous strobe. The default is 1000. Fewer ticks leave the time unchanged.
- R3: In running mode, each strobe adds one second. 59 seconds rolls over into the minutes, 59 minutes rolls over into the hours, and 23:59:59 wraps to 00:00:00.
- R4: Mode encoding is 0 running, 1 hour edit, 2 minute edit, 3 second edit. The mode output follows the switches one clock later. The hour switch wins over minute, and minute wins over second. With all three off the mode is running.
- R5: In any edit mode the time does not advance. With neither up nor down on, all three fields hold across strobes.
- R6: With up on in an edit mode, the selected field rises by one per strobe. Hours wrap from 23 to 0, and minutes or seconds wrap from 59 to 0.
- R7: With down on (and up off) in an edit mode, the selected field falls by one per strobe. Hours wrap from 0 to 23, and minutes or seconds wrap from 0 to 59.
- R8: When up and down are both on, the field steps up.
- R9: An edit step never carries into or borrows from another field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sel_hour | input | 1 | Hour edit switch |
| sel_min | input | 1 | Minute edit switch |
| sel_sec | input | 1 | Second edit switch |
| step_up | input | 1 | Increment switch |
| step_dn | input | 1 | Decrement switch |
| hours | output | 5 | Hours, 0 to 23 |
| minutes | output | 6 | Minutes, 0 to 59 |
| seconds | output | 6 | Seconds, 0 to 59 |
| mode | output | 2 | Current mode (encoding in R4) |

## Verification
Two situations are hard to reach from the ports. The first is an edit-mode wrap, such as minutes going from 59 to 0 while the hour holds. The second is a running rollover across a full hour. Both need many strobes at a fixed switch setting. The bench therefore builds the block with a short prescaler of eight ticks and counts ticks exactly. It walks a chained table in which each row starts from the time the previous row left. This lets it land a field on a wrap boundary before the next row steps across it, and set every switch at once to exercise the priorities. A directed case resets the block part-way through a second, to show that the prescaler restarts.

// File: rtl/clkedit_pkg.sv
package clkedit_pkg;

    localparam int HH_W = 5;
    localparam int MS_W = 6;

    localparam logic [HH_W-1:0] HH_LAST = HH_W'(23);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(59);

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HOUR = 2'd1,
        MODE_MIN  = 2'd2,
        MODE_SEC  = 2'd3
    } edit_mode_e;

    typedef struct packed {
        logic [HH_W-1:0] hh;
        logic [MS_W-1:0] mm;
        logic [MS_W-1:0] ss;
    } tod_t;

    function automatic logic [HH_W-1:0] hh_inc(input logic [HH_W-1:0] v);
        return (v >= HH_LAST) ? '0 : v + HH_W'(1);
    endfunction

    function automatic logic [HH_W-1:0] hh_dec(input logic [HH_W-1:0] v);
        return (v == '0) ? HH_LAST : v - HH_W'(1);
    endfunction

    function automatic logic [MS_W-1:0] ms_inc(input logic [MS_W-1:0] v);
        return (v >= MS_LAST) ? '0 : v + MS_W'(1);
    endfunction

    function automatic logic [MS_W-1:0] ms_dec(input logic [MS_W-1:0] v);
        return (v == '0) ? MS_LAST : v - MS_W'(1);
    endfunction

endpackage

// File: rtl/sec_strobe.sv
module sec_strobe #(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    pulse_d;

    always_comb begin
        st_d    = st_q;
        pulse_d = 1'b0;
        if (ms_tick) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                pulse_d  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_pulse = pulse_d;

    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !ms_tick |=> $stable(st_q.cnt));
    a_r2_pulse_needs_tick: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> ms_tick);
    a_r1_cleared: assert property (@(posedge clk)
        rst |=> st_q.cnt == '0);

endmodule

// File: rtl/edit_mode_fsm.sv
module edit_mode_fsm
    import clkedit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_hour,
    input  logic       sel_min,
    input  logic       sel_sec,
    output edit_mode_e mode_o
);
    typedef struct packed {
        edit_mode_e mode;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_hour) begin
            st_d.mode = MODE_HOUR;
        end else if (sel_min) begin
            st_d.mode = MODE_MIN;
        end else if (sel_sec) begin
            st_d.mode = MODE_SEC;
        end else begin
            st_d.mode = MODE_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    a_r4_hour_first: assert property (@(posedge clk) disable iff (rst)
        sel_hour |=> mode_o == MODE_HOUR);
    a_r4_min_over_sec: assert property (@(posedge clk) disable iff (rst)
        (!sel_hour && sel_min) |=> mode_o == MODE_MIN);
    a_r4_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        (!sel_hour && !sel_min && !sel_sec) |=> mode_o == MODE_RUN);

endmodule

// File: rtl/tod_core.sv
module tod_core
    import clkedit_pkg::*;
#(
    parameter logic [HH_W-1:0] INIT_HH = HH_W'(19),
    parameter logic [MS_W-1:0] INIT_MM = MS_W'(55),
    parameter logic [MS_W-1:0] INIT_SS = MS_W'(50)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_pulse,
    input  edit_mode_e mode,
    input  logic       step_up,
    input  logic       step_dn,
    output tod_t       tod_o
);
    tod_t st_d, st_q;
    logic do_step;

    assign do_step = step_up | step_dn;

    always_comb begin
        st_d = st_q;
        if (sec_pulse) begin
            unique case (mode)
                MODE_RUN: begin
                    st_d.ss = ms_inc(st_q.ss);
                    if (st_q.ss == MS_LAST) begin
                        st_d.mm = ms_inc(st_q.mm);
                        if (st_q.mm == MS_LAST) begin
                            st_d.hh = hh_inc(st_q.hh);
                        end
                    end
                end
                MODE_HOUR: begin
                    if (do_step) begin
                        st_d.hh = step_up ? hh_inc(st_q.hh) : hh_dec(st_q.hh);
                    end
                end
                MODE_MIN: begin
                    if (do_step) begin
                        st_d.mm = step_up ? ms_inc(st_q.mm) : ms_dec(st_q.mm);
                    end
                end
                MODE_SEC: begin
                    if (do_step) begin
                        st_d.ss = step_up ? ms_inc(st_q.ss) : ms_dec(st_q.ss);
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.hh <= INIT_HH;
            st_q.mm <= INIT_MM;
            st_q.ss <= INIT_SS;
        end else begin
            st_q <= st_d;
        end
    end

    assign tod_o = st_q;

    a_r3_legal_range: assert property (@(posedge clk) disable iff (rst)
        st_q.hh <= HH_LAST && st_q.mm <= MS_LAST && st_q.ss <= MS_LAST);
    a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !sec_pulse |=> $stable(st_q));
    a_r5_idle_edit_hold: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_RUN && !step_up && !step_dn) |=> $stable(st_q));
    a_r9_sec_edit_isolated: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SEC) |=> ($stable(st_q.hh) && $stable(st_q.mm)));
    a_r9_min_edit_isolated: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_MIN) |=> ($stable(st_q.hh) && $stable(st_q.ss)));
    a_r9_hour_edit_isolated: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOUR) |=> ($stable(st_q.mm) && $stable(st_q.ss)));
    a_r1_reset_time: assert property (@(posedge clk)
        rst |=> (st_q.hh == INIT_HH && st_q.mm == INIT_MM && st_q.ss == INIT_SS));

endmodule

// File: rtl/clock_edit_ctrl.sv
module clock_edit_ctrl
    import clkedit_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            sel_hour,
    input  logic            sel_min,
    input  logic            sel_sec,
    input  logic            step_up,
    input  logic            step_dn,
    output logic [HH_W-1:0] hours,
    output logic [MS_W-1:0] minutes,
    output logic [MS_W-1:0] seconds,
    output logic [1:0]      mode
);
    logic       sec_pulse;
    edit_mode_e mode_q;
    tod_t       tod;

    sec_strobe #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .ms_tick  (ms_tick),
        .sec_pulse(sec_pulse)
    );

    edit_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sel_hour(sel_hour),
        .sel_min (sel_min),
        .sel_sec (sel_sec),
        .mode_o  (mode_q)
    );

    tod_core #(
        .INIT_HH(HH_W'(19)),
        .INIT_MM(MS_W'(55)),
        .INIT_SS(MS_W'(50))
    ) u_tod (
        .clk      (clk),
        .rst      (rst),
        .sec_pulse(sec_pulse),
        .mode     (mode_q),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .tod_o    (tod)
    );

    assign hours   = tod.hh;
    assign minutes = tod.mm;
    assign seconds = tod.ss;
    assign mode    = mode_q;

endmodule

// File: tb/clock_edit_ctrl_bench.sv
module clock_edit_ctrl_bench;
    localparam int T  = 8;
    localparam int NV = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       sel_hour = 1'b0, sel_min = 1'b0, sel_sec = 1'b0;
    logic       step_up = 1'b0, step_dn = 1'b0;
    logic [4:0] hours;
    logic [5:0] minutes, seconds;
    logic [1:0] mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    clock_edit_ctrl #(.TICKS_PER_SEC(T)) u_clock_edit_ctrl (
        .clk(clk), .rst(rst), .ms_tick(ms_tick),
        .sel_hour(sel_hour), .sel_min(sel_min), .sel_sec(sel_sec),
        .step_up(step_up), .step_dn(step_dn),
        .hours(hours), .minutes(minutes), .seconds(seconds), .mode(mode)
    );

    // entry: {sel hour,min,sec}, up, dn, seconds applied, exp hh, mm, ss, mode
    // rows chain: each starts from the time left by the one before
    localparam logic [35:0] VEC [NV] = '{
        {3'b000, 1'b0, 1'b0, 12'd5,    5'd19, 6'd55, 6'd55, 2'd0}, // R3
        {3'b000, 1'b0, 1'b0, 12'd10,   5'd19, 6'd56, 6'd5,  2'd0}, // R3 carry
        {3'b001, 1'b1, 1'b0, 12'd56,   5'd19, 6'd56, 6'd1,  2'd3}, // R6 R9
        {3'b001, 1'b0, 1'b1, 12'd3,    5'd19, 6'd56, 6'd58, 2'd3}, // R7
        {3'b001, 1'b0, 1'b0, 12'd4,    5'd19, 6'd56, 6'd58, 2'd3}, // R5
        {3'b010, 1'b1, 1'b0, 12'd4,    5'd19, 6'd0,  6'd58, 2'd2}, // R6 R9
        {3'b010, 1'b0, 1'b1, 12'd1,    5'd19, 6'd59, 6'd58, 2'd2}, // R7
        {3'b100, 1'b1, 1'b0, 12'd5,    5'd0,  6'd59, 6'd58, 2'd1}, // R6
        {3'b100, 1'b0, 1'b1, 12'd1,    5'd23, 6'd59, 6'd58, 2'd1}, // R7
        {3'b000, 1'b0, 1'b0, 12'd2,    5'd0,  6'd0,  6'd0,  2'd0}, // R3 midnight
        {3'b111, 1'b1, 1'b1, 12'd1,    5'd1,  6'd0,  6'd0,  2'd1}, // R4 R8
        {3'b011, 1'b1, 1'b1, 12'd1,    5'd1,  6'd1,  6'd0,  2'd2}, // R4 R8
        {3'b001, 1'b0, 1'b1, 12'd1,    5'd1,  6'd1,  6'd59, 2'd3}, // R7 R9
        {3'b000, 1'b0, 1'b0, 12'd61,   5'd1,  6'd3,  6'd0,  2'd0}, // R3
        {3'b000, 1'b0, 1'b0, 12'd3540, 5'd2,  6'd2,  6'd0,  2'd0}  // R3 hour carry
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 9, 13, 14: return "R3";
            2, 5, 7:         return "R6";
            3, 6, 8, 12:     return "R7";
            4:               return "R5";
            default:         return "R4/R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] eh, input logic [5:0] em,
                         input logic [5:0] es, input logic [1:0] emd);
        n_checks++;
        if (hours !== eh || minutes !== em || seconds !== es || mode !== emd) begin
            n_fail++;
            $display("FAIL %s: got %0d:%0d:%0d mode %0d, expected %0d:%0d:%0d mode %0d",
                     tag, hours, minutes, seconds, mode, eh, em, es, emd);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            @(negedge clk);
        end
        ms_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", 5'd19, 6'd55, 6'd50, 2'd0);

        // R2: one tick short of a second leaves time unchanged
        ticks(T - 1);
        check("R2 short", 5'd19, 6'd55, 6'd50, 2'd0);
        ticks(1);
        check("R2 strobe", 5'd19, 6'd55, 6'd51, 2'd0);

        // R1: reset mid-second restores time and clears prescaler
        ticks(T - 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset", 5'd19, 6'd55, 6'd50, 2'd0);
        ticks(T - 1);
        check("R1 prescaler cleared", 5'd19, 6'd55, 6'd50, 2'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {sel_hour, sel_min, sel_sec} = VEC[i][35:33];
            step_up = VEC[i][32];
            step_dn = VEC[i][31];
            @(negedge clk);
            ticks(int'(VEC[i][30:19]) * T);
            check(vec_tag(i), VEC[i][18:14], VEC[i][13:8], VEC[i][7:2], VEC[i][1:0]);
        end

        // R4: mode output lags the switches by exactly one clock
        {sel_hour, sel_min, sel_sec} = 3'b010;
        step_up = 1'b0;
        step_dn = 1'b0;
        #1;
        check("R4 lag", 5'd2, 6'd2, 6'd0, 2'd0);
        @(negedge clk);
        check("R4 follow", 5'd2, 6'd2, 6'd0, 2'd2);

        // R5: held edit with up/down off, several seconds
        ticks(3 * T);
        check("R5 frozen", 5'd2, 6'd2, 6'd0, 2'd2);
        sel_min = 1'b0;
        @(negedge clk);
        check("R4 back to run", 5'd2, 6'd2, 6'd0, 2'd0);

        finish_run();
    end
endmodule